// File: doc/BRIEF.md
# Three/Four-Wire Serial Register Slave

This block is a serial register-access slave. A host frames each access with an active-low enable. It clocks a 16-bit instruction, then a 16-bit data word, most significant bit first. The instruction's top bit chooses write (1) or read (0). Its remaining 15 bits form an address: a 9-bit module field above a 6-bit register index. Only frames whose module field equals the block's configured module number touch the local register bank.

The serial clock, enable and input data are brought into the system clock domain through two-stage synchronizers. Input bits are taken on serial-clock rising edges, and read bits are launched on falling edges. In four-wire mode, read data leaves on a dedicated output. In three-wire mode it is driven back on the shared data line after the last address bit. The pad tristate is represented by an output-enable per line. Any number of instruction/data pairs can be streamed while the enable stays low.

Top module: `spi_reg_slave`

## Requirements
- R1: While reset is active and just after it, both output enables are low and every register in the bank reads 0.
- R2: Instruction bit 15 = 1 marks a write, bits 14..6 are the module field, and bits 5..0 are the register index. On a write whose module field equals MOD_ADDR, the 16 data bits, MSB first, are stored in the register selected by the index.
- R3: In four-wire mode (mode_3wire low at reset), a read drives D15 on sdo with sdo_en high from the serial-clock fall after the 16th rising edge, one bit per fall. sdio_oe stays low, and whatever is on sdio_in during the read data phase changes no register.
- R4: mode_3wire is captured while reset is active. When it was high, read data appears on sdio_out with sdio_oe high and with the same timing as R3, and sdo_en stays low.
- R5: Several instruction/data pairs under one enable assertion are each decoded and executed independently, with no gap between pairs.
- R6: Raising the enable before the 32nd rising edge of a frame discards that frame with no register change, and the next frame starts at bit 0.
- R7: Both output enables are low whenever the enable input is high, during every instruction phase, and during the data phase of writes.
- R8: A frame whose module field differs from MOD_ADDR writes nothing and, if a read, leaves both output enables low.
- R9: With a matching module field and an index at or above NREGS, a write changes no register, and a read drives sixteen 0 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_3wire | input | 1 | 1 selects three-wire reads, 0 four-wire; captured during reset |
| sen_n | input | 1 | Active-low frame enable |
| sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Serial data into the block (shared line, input side) |
| sdio_out | output | 1 | Read data for the shared line in three-wire mode |
| sdio_oe | output | 1 | Drive enable of the shared line |
| sdo | output | 1 | Read data on the dedicated output line |
| sdo_en | output | 1 | Drive enable of the dedicated output line |

## Verification
The bench aims at the turnaround point. A slave that launched D15 one edge early or late would return a shifted word and a wrong count of driven bits. It also checks which line carries data in each mode, since a mode mix-up would enable the wrong driver. Frames cut short by the enable are followed by a readback, so a partial write or a stale bit counter would show up as corrupted data. Foreign module numbers and indices past the bank end are also tried: a decoder that ignored the module field, or folded the index modulo the bank size, would overwrite a live register or answer a read that belongs to another slave.

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int         NREGS    = 8,
  parameter logic [8:0] MOD_ADDR = 9'h005
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_3wire,
  input  logic sen_n,
  input  logic sclk,
  input  logic sdio_in,
  output logic sdio_out,
  output logic sdio_oe,
  output logic sdo,
  output logic sdo_en
);
  localparam int         IW  = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [6:0] NR7 = 7'(NREGS);

  logic [2:0]  sclk_s;
  logic [1:0]  sen_s, din_s;
  logic        mode3, rd_act, wr_q, drive, outbit;
  logic [4:0]  bitcnt;
  logic [15:0] sh, rsh, rd_word;
  logic [14:0] addr_q;
  logic [15:0] regs [NREGS];

  wire        rise   = sclk_s[1] & ~sclk_s[2];
  wire        fall   = ~sclk_s[1] & sclk_s[2];
  wire        active = ~sen_s[1];
  wire [15:0] nxt    = {sh[14:0], din_s[1]};
  wire        instr_done = active & rise & (bitcnt == 5'd15);
  wire        data_done  = active & rise & (bitcnt == 5'd31);
  wire        hit_new = (nxt[14:6] == MOD_ADDR);
  wire        hit_q   = (addr_q[14:6] == MOD_ADDR);
  wire        we = data_done & wr_q & hit_q & ({1'b0, addr_q[5:0]} < NR7);

  always_comb begin
    rd_word = '0;
    if ({1'b0, nxt[5:0]} < NR7) rd_word = regs[nxt[IW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      sen_s  <= 2'b11;
      din_s  <= '0;
      mode3  <= mode_3wire;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      sen_s  <= {sen_s[0], sen_n};
      din_s  <= {din_s[0], sdio_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      sh     <= '0;
      rsh    <= '0;
      addr_q <= '0;
      wr_q   <= 1'b0;
      rd_act <= 1'b0;
      drive  <= 1'b0;
      outbit <= 1'b0;
    end else if (!active) begin
      bitcnt <= '0;
      rd_act <= 1'b0;
      drive  <= 1'b0;
    end else if (rise) begin
      bitcnt <= bitcnt + 5'd1;
      sh     <= nxt;
      if (instr_done) begin
        wr_q   <= nxt[15];
        addr_q <= nxt[14:0];
        rd_act <= ~nxt[15] & hit_new;
        rsh    <= rd_word;
      end
    end else if (fall) begin
      if (rd_act && bitcnt[4]) begin
        drive  <= 1'b1;
        outbit <= rsh[15];
        rsh    <= {rsh[14:0], 1'b0};
      end else begin
        drive  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we) begin
      regs[addr_q[IW-1:0]] <= nxt;
    end
  end

  assign sdo      = outbit;
  assign sdio_out = outbit;
  assign sdo_en   = drive & ~mode3;
  assign sdio_oe  = drive & mode3;

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !(sdo_en || sdio_oe)); // R7
  AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> rd_act); // R8
  AST_TURNAROUND_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive) |-> (bitcnt == 5'd16)); // R3
  AST_WRITE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (bitcnt == 5'd0)); // R5
  AST_COUNT_ON_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !rise) |=> $stable(bitcnt)); // R6
endmodule

// File: tb/test_spi_reg_slave.sv
`timescale 1ns/1ps
module test_spi_reg_slave;
  logic clk = 1'b0, rst_n = 1'b0, mode_3wire = 1'b0;
  logic sen_n = 1'b1, sclk = 1'b0, sdio_in = 1'b0;
  logic sdio_out, sdio_oe, sdo, sdo_en;
  int   errors = 0, checks = 0;
  logic cur_mode = 1'b0;

  spi_reg_slave #(.NREGS(8), .MOD_ADDR(9'h005)) i_spi_reg_slave (
    .clk(clk), .rst_n(rst_n), .mode_3wire(mode_3wire), .sen_n(sen_n),
    .sclk(sclk), .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
    .sdo(sdo), .sdo_en(sdo_en));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst_n = 1'b0; mode_3wire = m; cur_mode = m; sen_n = 1'b1; sclk = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [15:0] ins(input logic wr, input logic [8:0] m, input logic [5:0] idx);
    return {wr, m, idx};
  endfunction

  task automatic frame(input logic [15:0] instr, input logic [15:0] wd, input int nbits,
                       output logic [15:0] rd, output int good, output int bad);
    rd = '0; good = 0; bad = 0;
    for (int i = 0; i < nbits; i++) begin
      logic ours, theirs, val;
      sclk = 1'b0;
      sdio_in = (i < 16) ? instr[15-i] : wd[31-i];
      repeat (6) @(negedge clk);
      ours   = cur_mode ? sdio_oe : sdo_en;
      theirs = cur_mode ? sdo_en : sdio_oe;
      val    = cur_mode ? sdio_out : sdo;
      if (theirs) bad++;
      if (i >= 16) begin
        if (ours) good++;
        rd[31-i] = val;
      end else if (ours) bad++;
      sclk = 1'b1;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic sen_on();
    @(negedge clk); sclk = 1'b0; sen_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sen_off();
    repeat (2) @(negedge clk);
    sclk = 1'b0; sen_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R7 release after frame", {sdo_en, sdio_oe}, 2'b00);
  endtask

  task automatic wr1(input logic [8:0] m, input logic [5:0] idx, input logic [15:0] d, input string tag);
    logic [15:0] rd; int g, b;
    sen_on();
    frame(ins(1'b1, m, idx), d, 32, rd, g, b);
    chk({tag, " write drives nothing (R7)"}, b + g, 0);
    sen_off();
  endtask

  task automatic rd1(input logic [8:0] m, input logic [5:0] idx, input logic [15:0] junk,
                     input logic [15:0] exp, input int exp_good, input string tag);
    logic [15:0] rd; int g, b;
    sen_on();
    frame(ins(1'b0, m, idx), junk, 32, rd, g, b);
    chk({tag, " driven bits"}, g, exp_good);
    chk({tag, " wrong-line drive"}, b, 0);
    if (exp_good > 0) chk({tag, " data"}, rd, exp);
    sen_off();
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk("R1 enables after reset", {sdo_en, sdio_oe}, 2'b00);
    rd1(9'h005, 6'd0, 16'h0, 16'h0000, 16, "R1 reg0");
    rd1(9'h005, 6'd7, 16'h0, 16'h0000, 16, "R1 reg7");
  endtask

  task automatic t_rw4();
    wr1(9'h005, 6'd3, 16'hA5C3, "R2 reg3");
    wr1(9'h005, 6'd5, 16'h1234, "R2 reg5");
    rd1(9'h005, 6'd3, 16'hFFFF, 16'hA5C3, 16, "R3 read reg3");
    rd1(9'h005, 6'd5, 16'h5A5A, 16'h1234, 16, "R2 read reg5");
    rd1(9'h005, 6'd3, 16'h0000, 16'hA5C3, 16, "R3 sdio ignored in read");
  endtask

  task automatic t_stream();
    logic [15:0] rd; int g, b;
    sen_on();
    frame(ins(1'b1, 9'h005, 6'd1), 16'h0F0F, 32, rd, g, b);
    chk("R5 stream write1 drives", g + b, 0);
    frame(ins(1'b0, 9'h005, 6'd1), 16'h0000, 32, rd, g, b);
    chk("R5 stream read1 data", rd, 16'h0F0F);
    chk("R5 stream read1 bits", g, 16);
    frame(ins(1'b1, 9'h005, 6'd2), 16'hBEEF, 32, rd, g, b);
    chk("R7 stream write after read drives", g + b, 0);
    frame(ins(1'b0, 9'h005, 6'd2), 16'h0000, 32, rd, g, b);
    chk("R5 stream read2 data", rd, 16'hBEEF);
    sen_off();
  endtask

  task automatic t_abort();
    logic [15:0] rd; int g, b;
    sen_on();
    frame(ins(1'b1, 9'h005, 6'd4), 16'h7777, 24, rd, g, b);
    sen_off();
    sen_on();
    frame(ins(1'b1, 9'h005, 6'd3), 16'h1111, 31, rd, g, b);
    sen_off();
    rd1(9'h005, 6'd4, 16'h0, 16'h0000, 16, "R6 aborted write reg4");
    rd1(9'h005, 6'd3, 16'h0, 16'hA5C3, 16, "R6 abort at bit 31 reg3");
  endtask

  task automatic t_mismatch();
    wr1(9'h006, 6'd3, 16'hDEAD, "R8 foreign write");
    rd1(9'h005, 6'd3, 16'h0, 16'hA5C3, 16, "R8 reg3 kept");
    rd1(9'h006, 6'd3, 16'h0, 16'h0000, 0, "R8 foreign read");
  endtask

  task automatic t_range();
    wr1(9'h005, 6'd10, 16'hFFFF, "R9 out-of-range write");
    rd1(9'h005, 6'd10, 16'h0, 16'h0000, 16, "R9 out-of-range read");
    rd1(9'h005, 6'd2, 16'h0, 16'hBEEF, 16, "R9 no alias reg2");
  endtask

  task automatic t_3wire();
    do_reset(1'b1);
    mode_3wire = 1'b0;
    wr1(9'h005, 6'd6, 16'hC001, "R4 3w write");
    rd1(9'h005, 6'd6, 16'h0, 16'hC001, 16, "R4 3w read");
    rd1(9'h005, 6'd3, 16'h0, 16'h0000, 16, "R1 3w reset cleared reg3");
  endtask

  logic done = 1'b0;
  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rw4();
    t_stream();
    t_abort();
    t_mismatch();
    t_range();
    t_3wire();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule